// File: doc/BRIEF.md
# FM-Compatible Timer Status Controller

This block holds the interrupt and status logic behind a sound board's FM-synthesizer compatible timer port. A host reaches it over a small byte-wide register bus: it writes an FM command byte, FM data bytes, a stored FM status byte, a timer control register and two 8-bit timer reload values. It reads back a status byte whose source depends on the control register. Two interval timers run from a clock-enable prescaler. One timer steps every 80 us and the other every 320 us. Each timer starts from its reload value and counts up to overflow.

Writes to the data port are steered by an auto-timer mode. When the last command byte was 0x04 and the control register allows it, a data write controls the timers. Otherwise the byte is stored as FM data and may raise an interrupt. The block keeps maskable and non-maskable timer flags in a status byte, and the timer bits of a global interrupt status byte. It drives an interrupt request whenever that global byte is non-zero.

Top module: `fm_timer_status_ctrl`

## Requirements
- R1: A read of address 0 returns the timer status byte when control bit 0 is 1, and otherwise returns the stored FM status byte, which is written at address 2.
- R2: With FM command 0x04 and control bit 0 equal to 0, a write to address 1 does one of two things. With data bit 7 set it clears status bits 7..5 and leaves the timer data register unchanged. With data bit 7 clear it loads the timer data register (read at address 4). The FM data byte is untouched in both cases.
- R3: Any other write to address 1 stores the FM data byte (read at address 1). If control bit 1 is 1, the same write also sets status bit 0, forces the global status to 0x10 and raises irq.
- R4: A control write (address 3) with bit 5 at 0 clears status bits 4..3. A control write with bit 1 at 0 clears status bit 0. After those clears, if status bits 0, 3 and 4 are all 0, global bit 4 is cleared.
- R5: A control write with bit 2 at 0 clears status bit 2 and global bit 2. A control write with bit 3 at 0 clears status bit 1 and global bit 3.
- R6: Timer 1 runs while timer data bit 0 is 1. It expires after (256 - reload1) ticks of 80 us and then reloads. On expiry it sets status bits 7 and 6 unless timer data bit 6 is 1. If control bit 2 is 1, it also sets status bit 2 and global bit 2.
- R7: Timer 2 runs while timer data bit 1 is 1. It expires after (256 - reload2) ticks of 320 us. On expiry it sets status bits 7 and 5 unless timer data bit 5 is 1. If control bit 3 is 1, it also sets status bit 1 and global bit 3.
- R8: irq is 1 exactly when the global status byte is non-zero, and it updates on the same clock edge as that byte.
- R9: A read strobe returns data with bus_rvalid one cycle later. The read map is: 0 status, 1 FM data, 2 FM command, 3 control, 4 timer data, 5 global status, 6 reload1, 7 reload2.
- R10: After reset all registers are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle:
- the status-port read selection;
- the clearing done by control writes;
- the interrupt raised by a plain data write;
- the clearing of maskable flags in auto-timer mode;
- the reload of each timer counter at overflow.

Only the bench scenarios can show the rest:
- timer expiry landing in the expected window after a start;
- the data-bit masks of the maskable flags;
- a timer expiring with its enable off, which leaves irq low;
- the long sequences that set a flag and then drop it again.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_STAT   = 3'd0;
  localparam logic [AW-1:0] A_DATA   = 3'd1;
  localparam logic [AW-1:0] A_CMD    = 3'd2;
  localparam logic [AW-1:0] A_CTRL   = 3'd3;
  localparam logic [AW-1:0] A_TDATA  = 3'd4;
  localparam logic [AW-1:0] A_GIRQ   = 3'd5;
  localparam logic [AW-1:0] A_RLD1   = 3'd6;
  localparam logic [AW-1:0] A_RLD2   = 3'd7;
  localparam int NTIMERS = 2;
endpackage

// File: rtl/fmt_prescaler.sv
module fmt_prescaler #(
  parameter int DIV = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = en && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assert_pre_range_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> (pre_q <= LAST));
endmodule

// File: rtl/fmt_timer.sv
module fmt_timer #(
  parameter int DIV = 4000,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          expire
);
  logic          tick;
  logic [CW-1:0] cnt_q;

  fmt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .en(run), .tick(tick)
  );

  assign expire = tick && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (!run) cnt_q <= reload;
    else if (tick) cnt_q <= (cnt_q == '1) ? reload : cnt_q + 1'b1;
  end

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/fm_timer_status_ctrl.sv
module fm_timer_status_ctrl
  import fmt_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int T1_US    = 80,
  parameter int T2_US    = 320,
  parameter logic [7:0] AUTO_CMD = 8'h04
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq
);
  localparam int CLK_KHZ = CLK_HZ / 1000;
  localparam int T1_DIV  = (CLK_KHZ * T1_US) / 1000;
  localparam int T2_DIV  = (CLK_KHZ * T2_US) / 1000;

  logic [DW-1:0] ctrl_q, ts_q, tdata_q, cmd_q, fdata_q, fstat_q, girq_q;
  logic [DW-1:0] ctrl_d, ts_d, tdata_d, cmd_d, fdata_d, fstat_d, girq_d;
  logic [DW-1:0] rld_q [NTIMERS];
  logic [DW-1:0] rld_d [NTIMERS];
  logic [NTIMERS-1:0] expire;
  logic auto_wr;

  genvar g;
  generate
    for (g = 0; g < NTIMERS; g++) begin : g_tmr
      localparam int TDIV = (g == 0) ? T1_DIV : T2_DIV;
      fmt_timer #(.DIV(TDIV), .CW(DW)) u_tmr (
        .clk(clk), .rst(rst), .run(tdata_q[g]),
        .reload(rld_q[g]), .expire(expire[g])
      );
    end
  endgenerate

  assign auto_wr = (cmd_q == AUTO_CMD) && !ctrl_q[0];

  always_comb begin
    ctrl_d = ctrl_q; ts_d = ts_q; tdata_d = tdata_q; cmd_d = cmd_q;
    fdata_d = fdata_q; fstat_d = fstat_q; girq_d = girq_q;
    for (int i = 0; i < NTIMERS; i++) rld_d[i] = rld_q[i];
    if (bus_wr) begin
      case (bus_addr)
        A_STAT: cmd_d = bus_wdata;
        A_DATA: begin
          if (auto_wr) begin
            if (bus_wdata[7]) ts_d[7:5] = 3'b000;
            else tdata_d = bus_wdata;
          end else begin
            fdata_d = bus_wdata;
            if (ctrl_q[1]) begin
              ts_d[0] = 1'b1;
              girq_d  = 8'h10;
            end
          end
        end
        A_CMD:  fstat_d = bus_wdata;
        A_CTRL: begin
          ctrl_d = bus_wdata;
          if (!bus_wdata[5]) ts_d[4:3] = 2'b00;
          if (!bus_wdata[1]) ts_d[0] = 1'b0;
          if ((ts_d & 8'h19) == 8'h00) girq_d[4] = 1'b0;
          if (!bus_wdata[2]) begin ts_d[2] = 1'b0; girq_d[2] = 1'b0; end
          if (!bus_wdata[3]) begin ts_d[1] = 1'b0; girq_d[3] = 1'b0; end
        end
        A_RLD1: rld_d[0] = bus_wdata;
        A_RLD2: rld_d[1] = bus_wdata;
        default: ;
      endcase
    end
    if (expire[0]) begin
      if (!tdata_q[6]) ts_d[7:6] = 2'b11;
      if (ctrl_d[2]) begin ts_d[2] = 1'b1; girq_d[2] = 1'b1; end
    end
    if (expire[1]) begin
      if (!tdata_q[5]) begin ts_d[7] = 1'b1; ts_d[5] = 1'b1; end
      if (ctrl_d[3]) begin ts_d[1] = 1'b1; girq_d[3] = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; ts_q <= '0; tdata_q <= '0; cmd_q <= '0;
      fdata_q <= '0; fstat_q <= '0; girq_q <= '0; irq <= 1'b0;
      for (int i = 0; i < NTIMERS; i++) rld_q[i] <= '0;
    end else begin
      ctrl_q <= ctrl_d; ts_q <= ts_d; tdata_q <= tdata_d; cmd_q <= cmd_d;
      fdata_q <= fdata_d; fstat_q <= fstat_d; girq_q <= girq_d;
      irq <= (girq_d != 8'h00);
      for (int i = 0; i < NTIMERS; i++) rld_q[i] <= rld_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          A_STAT:  bus_rdata <= ctrl_q[0] ? ts_q : fstat_q;
          A_DATA:  bus_rdata <= fdata_q;
          A_CMD:   bus_rdata <= cmd_q;
          A_CTRL:  bus_rdata <= ctrl_q;
          A_TDATA: bus_rdata <= tdata_q;
          A_GIRQ:  bus_rdata <= girq_q;
          A_RLD1:  bus_rdata <= rld_q[0];
          default: bus_rdata <= rld_q[1];
        endcase
      end
    end
  end

  assert_stat_select_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=>
      (bus_rvalid && bus_rdata == ($past(ctrl_q[0]) ? $past(ts_q) : $past(fstat_q))));

  assert_auto_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && auto_wr && bus_wdata[7] && expire == '0)
      |=> (ts_q[7:5] == 3'b000 && $stable(tdata_q)));

  assert_data_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && !auto_wr && ctrl_q[1]) |=> (irq && ts_q[0]));

  assert_ctrl_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL && !bus_wdata[1] && !bus_wdata[5])
      |=> (ts_q[0] == 1'b0 && ts_q[4:3] == 2'b00 && !girq_q[4]));

  assert_nmi_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL && !bus_wdata[2]) |=> (!ts_q[2] && !girq_q[2]));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> (girq_q == 8'h00));
endmodule

// File: tb/fm_timer_status_ctrl_test.sv
module fm_timer_status_ctrl_test;
  localparam int CLK_HZ = 250_000;
  localparam int D1 = 20;
  localparam int D2 = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  fm_timer_status_ctrl #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read data %02h, expected none", "R9", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: read %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk_irq(1'b0, "R10");
    rd(3'd0, 8'h00, "R10");
    rd(3'd5, 8'h00, "R10");
    rd(3'd3, 8'h00, "R10");
    // R1 stored FM status selected when control bit 0 clear
    wr(3'd2, 8'h5A);
    rd(3'd0, 8'h5A, "R1");
    // R3 plain data write, no irq enable
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h33);
    rd(3'd1, 8'h33, "R3");
    chk_irq(1'b0, "R3");
    rd(3'd2, 8'h02, "R9");
    // R3 with irq enable
    wr(3'd3, 8'h02);
    wr(3'd1, 8'h44);
    chk_irq(1'b1, "R3");
    rd(3'd5, 8'h10, "R3");
    wr(3'd3, 8'h03);
    rd(3'd0, 8'h01, "R1");
    // R4 dropping control bit 1
    wr(3'd3, 8'h01);
    chk_irq(1'b0, "R4");
    rd(3'd0, 8'h00, "R4");
    rd(3'd5, 8'h00, "R4");
    // R6 timer 1 with enables
    wr(3'd6, 8'hFE);
    wr(3'd7, 8'hFF);
    rd(3'd6, 8'hFE, "R9");
    wr(3'd3, 8'h0C);
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h01);
    wait_n(2 * D1 - 3);
    chk_irq(1'b0, "R6");
    wait_n(6);
    chk_irq(1'b1, "R6");
    rd(3'd5, 8'h04, "R6");
    wr(3'd3, 8'h0D);
    rd(3'd0, 8'hC4, "R6");
    // R2 with control bit 0 set, data goes to FM data
    wr(3'd1, 8'h05);
    rd(3'd1, 8'h05, "R2");
    rd(3'd4, 8'h01, "R2");
    wr(3'd3, 8'h0C);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h80);
    rd(3'd4, 8'h00, "R2");
    rd(3'd1, 8'h05, "R2");
    // R5 drop non-maskable enables
    wr(3'd3, 8'h01);
    chk_irq(1'b0, "R5");
    rd(3'd0, 8'h00, "R5");
    // R7 timer 2 masked
    wr(3'd3, 8'h08);
    wr(3'd1, 8'h22);
    wait_n(D2 - 3);
    chk_irq(1'b0, "R7");
    wait_n(6);
    chk_irq(1'b1, "R7");
    wr(3'd3, 8'h09);
    rd(3'd0, 8'h02, "R7");
    rd(3'd5, 8'h08, "R8");
    wr(3'd3, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
    chk_irq(1'b0, "R8");
    rd(3'd5, 8'h00, "R5");
    // R6 expiry with enable off leaves irq low
    wr(3'd1, 8'h01);
    wait_n(2 * D1 + 5);
    chk_irq(1'b0, "R6");
    wr(3'd3, 8'h01);
    rd(3'd0, 8'hC0, "R6");
    rd(3'd5, 8'h00, "R6");
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h80);
    wr(3'd3, 8'h01);
    rd(3'd0, 8'h00, "R2");
    wait_n(4);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9: %0d reads unanswered, expected 0", sb_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule